// File: doc/BRIEF.md
# Test-Access Instruction Register and Decoder

This block holds the 6-bit instruction register of a boundary-scan test port and turns the held instruction into the controls that the rest of the scan logic needs. These controls are which data register sits between the serial input and output, which source drives the serial output, whether the functional core is held in reset, and how the device output pins behave. The state machine that walks the port states is outside the block. It feeds the block one-hot state strobes. The boundary register and the test-control register are also outside the block, and the block tells them when they are the active path. Two small data registers are kept inside: the fixed 32-bit identification register and the 1-bit bypass register.

All shifting and capturing happens on the rising test clock. The instruction that drives the decoded outputs is copied from the shift stage on the falling test clock in the update state, so the decoded outputs never move while a new instruction is being shifted in. Leaving reset, or passing through the reset state of the port, makes the identification register the active data path with no instruction scan.

Top module: `jtag_ir_ctrl`

## Requirements
- R1: While `trst_n` is low, and after any falling `tck` edge with `tlr` high, the held instruction is IDCODE (000001). The outputs are then `dr_sel`=01, `pin_mode`=00, `func_rst`=0 and `tctrl_sel`=0.
- R2: A rising `tck` edge with `cap_ir` high loads 000001 into the shift stage. A rising edge with `sh_ir` high shifts `tdi` in at bit 5. While `sh_ir` is high, `ser_out` shows bit 0, so the first bit out after a capture is 1 and the next five are 0.
- R3: The decoded outputs change only on a falling `tck` edge with `upd_ir` high (or `tlr` high). Capturing and shifting the instruction leave them unchanged.
- R4: EXTEST (000000) gives `dr_sel`=00 (boundary), `pin_mode`=01 (drive from update cells) and `func_rst`=1.
- R5: SAMPLE/PRELOAD (000010) gives `dr_sel`=00, `pin_mode`=00 (normal) and `func_rst`=0.
- R6: ENABLE (000011) gives `dr_sel`=11 (test-control register), `tctrl_sel`=1, `pin_mode`=00 and `func_rst`=0. `tctrl_sel` is 0 for every other opcode.
- R7: CLAMP (011111) gives `dr_sel`=10 (bypass), `pin_mode`=01 and `func_rst`=1.
- R8: HIGHZ (111101) gives `dr_sel`=10, `pin_mode`=10 (tri-state) and `func_rst`=1.
- R9: BYPASS (111111) gives `dr_sel`=10, `pin_mode`=00 and `func_rst`=0. Every opcode not named in R1 or R4 to R8 decodes the same way.
- R10: With IDCODE held, a rising edge with `cap_dr` high loads `ID_VALUE` with bit 0 forced to 1. Rising edges with `sh_dr` high shift the register LSB first, with `tdi` entering at bit 31, and `ser_out` shows bit 0.
- R11: With the bypass register selected, a rising edge with `cap_dr` high loads 0. Each rising edge with `sh_dr` high loads `tdi`, and `ser_out` shows the stored bit.
- R12: `ext_tdo_sel` is 1 exactly when `sh_ir` is 0 and `dr_sel` is 00 or 11. When it is 1, the external register should drive the serial output. When `dr_sel` is 00 or 11 and `sh_ir` is 0, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tlr | input | 1 | Port is in the Test-Logic-Reset state |
| cap_ir | input | 1 | Port is in Capture-IR |
| sh_ir | input | 1 | Port is in Shift-IR |
| upd_ir | input | 1 | Port is in Update-IR |
| cap_dr | input | 1 | Port is in Capture-DR |
| sh_dr | input | 1 | Port is in Shift-DR |
| tdi | input | 1 | Serial test data in |
| dr_sel | output | 2 | Active data register: 00 boundary, 01 identification, 10 bypass, 11 test-control |
| ser_out | output | 1 | Serial data from the internal source (instruction stage, identification or bypass) |
| ext_tdo_sel | output | 1 | External register drives the serial output |
| func_rst | output | 1 | Functional core reset request |
| pin_mode | output | 2 | 00 normal, 01 drive from update cells, 10 tri-state |
| tctrl_sel | output | 1 | Test-control register selected |

## Verification
The hardest case to reach from the ports is the window between shifting a new opcode in and updating it. There the shift stage already holds the new pattern while the decoded outputs must still show the old instruction. Every opcode load in the bench compares the outputs against the previous instruction just before the update strobe, so this window is checked once for each transition. The bench sweeps all 64 opcodes in sequence, which makes each one the previous instruction of the next. The bench also loads IDCODE and the bypass register and shifts each one past its length, so the captured bits and the bits entering from `tdi` both appear at the output.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;

    localparam int IR_W = 6;

    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t OP_EXTEST  = 6'b000000;
    localparam ir_t OP_IDCODE  = 6'b000001;
    localparam ir_t OP_SAMPLE  = 6'b000010;
    localparam ir_t OP_ENABLE  = 6'b000011;
    localparam ir_t OP_CLAMP   = 6'b011111;
    localparam ir_t OP_HIGHZ   = 6'b111101;
    localparam ir_t OP_BYPASS  = 6'b111111;

    localparam ir_t IR_CAPTURE_PAT = 6'b000001;

    typedef enum logic [1:0] {
        DR_BOUNDARY = 2'b00,
        DR_IDCODE   = 2'b01,
        DR_BYPASS   = 2'b10,
        DR_TESTCTRL = 2'b11
    } dr_sel_e;

    typedef enum logic [1:0] {
        PIN_NORMAL = 2'b00,
        PIN_UPDATE = 2'b01,
        PIN_HIZ    = 2'b10
    } pin_mode_e;

    typedef struct packed {
        dr_sel_e   dr;
        pin_mode_e pin;
        logic      func_rst;
        logic      tctrl;
    } decode_t;

endpackage

// File: rtl/jtag_ir_reg.sv
module jtag_ir_reg
    import jtag_ir_pkg::*;
(
    input  logic tck,
    input  logic trst_n,
    input  logic tlr,
    input  logic cap_ir,
    input  logic sh_ir,
    input  logic upd_ir,
    input  logic tdi,
    output ir_t  instr_q,
    output logic ir_so
);

    // Shift stage, rising edge
    ir_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (cap_ir) begin
            sr_d = IR_CAPTURE_PAT;
        end else if (sh_ir) begin
            sr_d = {tdi, sr_q[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= IR_CAPTURE_PAT;
        end else begin
            sr_q <= sr_d;
        end
    end

    // Held instruction, falling edge
    ir_t instr_d;

    always_comb begin
        instr_d = instr_q;
        if (tlr) begin
            instr_d = OP_IDCODE;
        end else if (upd_ir) begin
            instr_d = sr_q;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            instr_q <= OP_IDCODE;
        end else begin
            instr_q <= instr_d;
        end
    end

    assign ir_so = sr_q[0];

    assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!trst_n)
        cap_ir |=> (ir_so == 1'b1));

    assert_ir_tlr_R1: assert property (@(negedge tck) disable iff (!trst_n)
        tlr |=> (instr_q == OP_IDCODE));

    assert_ir_hold_R3: assert property (@(negedge tck) disable iff (!trst_n)
        (!tlr && !upd_ir) |=> $stable(instr_q));

endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
    import jtag_ir_pkg::*;
(
    input  ir_t     instr,
    output decode_t dec
);

    always_comb begin
        dec.dr       = DR_BYPASS;
        dec.pin      = PIN_NORMAL;
        dec.func_rst = 1'b0;
        dec.tctrl    = 1'b0;
        case (instr)
            OP_EXTEST: begin
                dec.dr       = DR_BOUNDARY;
                dec.pin      = PIN_UPDATE;
                dec.func_rst = 1'b1;
            end
            OP_IDCODE: begin
                dec.dr = DR_IDCODE;
            end
            OP_SAMPLE: begin
                dec.dr = DR_BOUNDARY;
            end
            OP_ENABLE: begin
                dec.dr    = DR_TESTCTRL;
                dec.tctrl = 1'b1;
            end
            OP_CLAMP: begin
                dec.pin      = PIN_UPDATE;
                dec.func_rst = 1'b1;
            end
            OP_HIGHZ: begin
                dec.pin      = PIN_HIZ;
                dec.func_rst = 1'b1;
            end
            default: begin
                // BYPASS and every undefined opcode keep the defaults
            end
        endcase
    end

endmodule

// File: rtl/jtag_fixed_dr.sv
module jtag_fixed_dr #(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0F3A_9C55
) (
    input  logic tck,
    input  logic trst_n,
    input  logic cap_dr,
    input  logic sh_dr,
    input  logic sel_id,
    input  logic sel_byp,
    input  logic tdi,
    output logic id_so,
    output logic byp_so
);

    localparam logic [ID_W-1:0] ID_CAP = ID_VALUE[ID_W-1:0] | {{(ID_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0] id_sr;
        logic            byp;
    } fdr_t;

    fdr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_id) begin
            if (cap_dr) begin
                st_d.id_sr = ID_CAP;
            end else if (sh_dr) begin
                st_d.id_sr = {tdi, st_q.id_sr[ID_W-1:1]};
            end
        end
        if (sel_byp) begin
            if (cap_dr) begin
                st_d.byp = 1'b0;
            end else if (sh_dr) begin
                st_d.byp = tdi;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            st_q.id_sr <= ID_CAP;
            st_q.byp   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_so  = st_q.id_sr[0];
    assign byp_so = st_q.byp;

    assert_id_capture_R10: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && sel_id) |=> (id_so == 1'b1));

    assert_byp_capture_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && sel_byp) |=> (byp_so == 1'b0));

    assert_byp_shift_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (sh_dr && !cap_dr && sel_byp) |=> (byp_so == $past(tdi)));

endmodule

// File: rtl/jtag_ir_ctrl.sv
module jtag_ir_ctrl
    import jtag_ir_pkg::*;
#(
    parameter int          ID_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h0F3A_9C55
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tlr,
    input  logic       cap_ir,
    input  logic       sh_ir,
    input  logic       upd_ir,
    input  logic       cap_dr,
    input  logic       sh_dr,
    input  logic       tdi,
    output logic [1:0] dr_sel,
    output logic       ser_out,
    output logic       ext_tdo_sel,
    output logic       func_rst,
    output logic [1:0] pin_mode,
    output logic       tctrl_sel
);

    ir_t     instr_q;
    logic    ir_so;
    decode_t dec;
    logic    id_so;
    logic    byp_so;

    jtag_ir_reg u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tlr     (tlr),
        .cap_ir  (cap_ir),
        .sh_ir   (sh_ir),
        .upd_ir  (upd_ir),
        .tdi     (tdi),
        .instr_q (instr_q),
        .ir_so   (ir_so)
    );

    jtag_ir_decode u_dec (
        .instr (instr_q),
        .dec   (dec)
    );

    jtag_fixed_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_fdr (
        .tck     (tck),
        .trst_n  (trst_n),
        .cap_dr  (cap_dr),
        .sh_dr   (sh_dr),
        .sel_id  (dec.dr == DR_IDCODE),
        .sel_byp (dec.dr == DR_BYPASS),
        .tdi     (tdi),
        .id_so   (id_so),
        .byp_so  (byp_so)
    );

    always_comb begin
        ser_out     = 1'b0;
        ext_tdo_sel = 1'b0;
        if (sh_ir) begin
            ser_out = ir_so;
        end else begin
            case (dec.dr)
                DR_IDCODE:   ser_out = id_so;
                DR_BYPASS:   ser_out = byp_so;
                default:     ext_tdo_sel = 1'b1;
            endcase
        end
    end

    assign dr_sel    = dec.dr;
    assign pin_mode  = dec.pin;
    assign func_rst  = dec.func_rst;
    assign tctrl_sel = dec.tctrl;

    assert_rst_pins_R4: assert property (@(posedge tck) disable iff (!trst_n)
        func_rst |-> (pin_mode != PIN_NORMAL));

    assert_tctrl_path_R6: assert property (@(posedge tck) disable iff (!trst_n)
        tctrl_sel |-> (dr_sel == DR_TESTCTRL && !func_rst));

    assert_ext_shift_ir_R12: assert property (@(posedge tck) disable iff (!trst_n)
        sh_ir |-> !ext_tdo_sel);

    assert_ext_quiet_R12: assert property (@(posedge tck) disable iff (!trst_n)
        ext_tdo_sel |-> !ser_out);

endmodule

// File: tb/tb_jtag_ir_ctrl.sv
module tb_jtag_ir_ctrl;

    localparam logic [31:0] ID_SET = 32'h3B7A_4C2E;
    localparam logic [31:0] ID_EXP = ID_SET | 32'd1;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tlr = 1'b0, cap_ir = 1'b0, sh_ir = 1'b0, upd_ir = 1'b0;
    logic cap_dr = 1'b0, sh_dr = 1'b0, tdi = 1'b0;
    logic [1:0] dr_sel, pin_mode;
    logic ser_out, ext_tdo_sel, func_rst, tctrl_sel;

    int checks = 0;
    int errors = 0;

    always #2.5 tck = ~tck;

    jtag_ir_ctrl #(.ID_W(32), .ID_VALUE(ID_SET)) dut (
        .tck(tck), .trst_n(trst_n), .tlr(tlr), .cap_ir(cap_ir), .sh_ir(sh_ir),
        .upd_ir(upd_ir), .cap_dr(cap_dr), .sh_dr(sh_dr), .tdi(tdi),
        .dr_sel(dr_sel), .ser_out(ser_out), .ext_tdo_sel(ext_tdo_sel),
        .func_rst(func_rst), .pin_mode(pin_mode), .tctrl_sel(tctrl_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    // expected {dr_sel, pin_mode, func_rst, tctrl_sel}
    function automatic logic [5:0] model(input logic [5:0] op);
        case (op)
            6'b000000: return {2'b00, 2'b01, 1'b1, 1'b0};  // R4
            6'b000001: return {2'b01, 2'b00, 1'b0, 1'b0};  // R1
            6'b000010: return {2'b00, 2'b00, 1'b0, 1'b0};  // R5
            6'b000011: return {2'b11, 2'b00, 1'b0, 1'b1};  // R6
            6'b011111: return {2'b10, 2'b01, 1'b1, 1'b0};  // R7
            6'b111101: return {2'b10, 2'b10, 1'b1, 1'b0};  // R8
            default:   return {2'b10, 2'b00, 1'b0, 1'b0};  // R9
        endcase
    endfunction

    function automatic string tag(input logic [5:0] op);
        case (op)
            6'b000000: return "R4";
            6'b000001: return "R1";
            6'b000010: return "R5";
            6'b000011: return "R6";
            6'b011111: return "R7";
            6'b111101: return "R8";
            default:   return "R9";
        endcase
    endfunction

    function automatic logic [5:0] outs();
        return {dr_sel, pin_mode, func_rst, tctrl_sel};
    endfunction

    task automatic load_ir(input logic [5:0] op, input logic [5:0] prev);
        cap_ir = 1'b1;
        step();
        cap_ir = 1'b0;
        sh_ir = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tdi = op[i];
            #1;
            chk("R2 ir shift-out", 32'(ser_out), (i == 0) ? 32'd1 : 32'd0);
            if (i == 0) chk("R12 ext during ir shift", 32'(ext_tdo_sel), 32'd0);
            step();
        end
        sh_ir = 1'b0;
        #1;
        chk("R3 outputs held before update", 32'(outs()), 32'(model(prev)));
        upd_ir = 1'b1;
        step();
        upd_ir = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] prev;
        logic       last_tdi;
        repeat (3) step();
        // R1: reset state
        chk("R1 reset decode", 32'(outs()), 32'(model(6'b000001)));
        trst_n = 1'b1;
        step();
        chk("R1 after reset release", 32'(outs()), 32'(model(6'b000001)));

        // R1: test-logic-reset after another instruction
        load_ir(6'b011111, 6'b000001);
        chk("R7 clamp", 32'(outs()), 32'(model(6'b011111)));
        tlr = 1'b1;
        step();
        tlr = 1'b0;
        #1;
        chk("R1 tlr returns idcode", 32'(outs()), 32'(model(6'b000001)));

        // exhaustive opcode sweep, R4..R9, R12
        prev = 6'b000001;
        for (int op = 0; op < 64; op++) begin
            logic [5:0] o;
            logic [5:0] e;
            o = 6'(op);
            load_ir(o, prev);
            e = model(o);
            chk({tag(o), " decode"}, 32'(outs()), 32'(e));
            chk("R12 ext_tdo_sel", 32'(ext_tdo_sel),
                (e[5:4] == 2'b00 || e[5:4] == 2'b11) ? 32'd1 : 32'd0);
            if (e[5:4] == 2'b00 || e[5:4] == 2'b11)
                chk("R12 ser_out quiet", 32'(ser_out), 32'd0);
            prev = o;
        end

        // R10: identification register capture and shift
        load_ir(6'b000001, prev);
        chk("R10 idcode selected", 32'(dr_sel), 32'd1);
        cap_dr = 1'b1;
        step();
        cap_dr = 1'b0;
        sh_dr = 1'b1;
        for (int i = 0; i < 36; i++) begin
            tdi = (i % 3 == 0);
            #1;
            if (i < 32)
                chk("R10 id bit", 32'(ser_out), 32'(ID_EXP[i]));
            else
                chk("R10 tdi through id", 32'(ser_out), ((i - 32) % 3 == 0) ? 32'd1 : 32'd0);
            step();
        end
        sh_dr = 1'b0;

        // R11: bypass capture 0, one-stage delay
        load_ir(6'b101010, 6'b000001);
        chk("R9 undefined opcode bypass", 32'(dr_sel), 32'd2);
        cap_dr = 1'b1;
        step();
        cap_dr = 1'b0;
        sh_dr = 1'b1;
        last_tdi = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tdi = k[0] ^ k[1];
            #1;
            chk("R11 bypass out", 32'(ser_out), 32'(last_tdi));
            last_tdi = tdi;
            step();
        end
        sh_dr = 1'b0;
        #1;
        chk("R11 bypass final", 32'(ser_out), 32'(last_tdi));
        chk("R3 decode held through dr ops", 32'(outs()), 32'(model(6'b101010)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule